// File: doc/BRIEF.md
# Triggered Timer Counter

This block is a timer counter that counts prescaled clock ticks up to a programmable modulo value, either wrapping back to zero (edge-aligned) or turning around and counting back down (centre-aligned). A power-of-two prescaler sets the tick rate. A one-cycle overflow pulse marks each period boundary. A sticky overflow flag, together with an enable, produces an interrupt request.

Run control depends on a trigger input and a few configuration bits. The counter can wait for a trigger before it starts. It can stop itself at the first overflow. It can return to zero on a trigger. It can hold while the trigger is high. It can also hold while a debug-halt input is asserted, unless the debug-run bit is set. A rising edge on the trigger is one event, however long the trigger stays high.

Top module: `tick_timer`

## Requirements
- R1: With PS = `ps_i`, the count advances once every 2^PS clocks while running. PS = 0 advances it on every clock. The first advance comes 2^PS clocks after the counter starts running.
- R2: Edge-aligned mode (`center_i` = 0) counts 0, 1, ..., MOD and then returns to 0. The period is MOD+1 ticks. With MOD = 0 the count stays at 0 and every tick overflows.
- R3: Centre-aligned mode (`center_i` = 1) counts from 0 up to MOD, then down to 0, giving a period of 2*MOD ticks. `dir_down_o` is 1 while the value is falling, meaning after the turn at MOD and until 0 is reached.
- R4: `ovf_pulse_o` is high for exactly one cycle, the cycle in which the count first shows the value after the period boundary. That value is 0 in edge-aligned mode and MOD-1 in centre-aligned mode.
- R5: `ovf_flag_o` is set by an overflow and stays set until a cycle with `ovf_clr_i` = 1 clears it. An overflow in the same cycle wins. `irq_o` is 1 exactly when the flag and `ovf_ie_i` are both 1.
- R6: While `en_i` = 0 the count holds its value and the prescaler is cleared.
- R7: With `start_on_trig_i` = 1, an enabled counter holds until a trigger rising edge. The clock with that edge counts as the first running clock. After that, the counter keeps running whatever the trigger does.
- R8: With `stop_on_ovf_i` = 1, the counter freezes at the value it shows after its first overflow. It stays frozen until `en_i` is dropped and raised again. With the bit clear, it keeps running past overflows.
- R9: With `reload_on_trig_i` = 1, a trigger rising edge sets the count to 0, sets the direction to up and restarts the prescaler. This happens in place of any advance, and no overflow is raised. A trigger held high reloads only once.
- R10: With `pause_on_trig_i` = 1, the count holds while `trig_i` is high.
- R11: With `dbg_run_i` = 0, the count holds while `dbg_halt_i` is high. With `dbg_run_i` = 1, the debug-halt input has no effect.

Top module ports (Verilog names): `clk_i`, `rst_ni`, `en_i`, `ps_i`, `mod_i`, `center_i`, `trig_i`, `start_on_trig_i`, `stop_on_ovf_i`, `reload_on_trig_i`, `pause_on_trig_i`, `dbg_run_i`, `dbg_halt_i`, `ovf_ie_i`, `ovf_clr_i`, `count_o`, `dir_down_o`, `ovf_pulse_o`, `ovf_flag_o`, `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counter enable |
| ps_i | input | PS_W (3) | Prescale exponent; divides the clock by 2^ps_i |
| mod_i | input | CNT_W (16) | Modulo value |
| center_i | input | 1 | 1 selects centre-aligned (up-down) counting |
| trig_i | input | 1 | Trigger input |
| start_on_trig_i | input | 1 | Wait for a trigger edge before counting |
| stop_on_ovf_i | input | 1 | Freeze at the first overflow |
| reload_on_trig_i | input | 1 | Trigger edge reloads the count to 0 |
| pause_on_trig_i | input | 1 | Hold while the trigger is high |
| dbg_run_i | input | 1 | 1 keeps counting during debug halt |
| dbg_halt_i | input | 1 | Debug halt request |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| count_o | output | CNT_W (16) | Count value |
| dir_down_o | output | 1 | 1 while counting down (centre-aligned) |
| ovf_pulse_o | output | 1 | One-cycle overflow pulse |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench sweeps prescale, modulo and mode together, so that an off-by-one in the prescaler's first tick shows up as a wrong count. So does a wrap at MOD instead of after MOD, or a turnaround that visits MOD or 0 twice. It targets MOD = 0 and MOD = 1, where a naive up-down counter underflows to the top of its range. A trigger held high over several clocks exposes a level-sensitive reload or start: such a design would pin the count at 0 instead of counting on. The stop, pause and debug cases check that the frozen value is the value after the overflow or the hold began, not one tick later.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

  typedef struct packed {
    logic start_on_trig;
    logic stop_on_ovf;
    logic reload_on_trig;
    logic pause_on_trig;
    logic dbg_run;
  } run_cfg_t;
endpackage

// File: rtl/tmr_trig_ctl.sv
module tmr_trig_ctl
  import tmr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     trig_i,
  input  logic     dbg_halt_i,
  input  run_cfg_t cfg_i,
  input  logic     wrap_i,
  output logic     active_o,
  output logic     advance_o,
  output logic     reload_o
);
  logic trig_q, started_q, stopped_q;
  logic trig_evt, hold;

  assign trig_evt = trig_i & ~trig_q;

  // running unless stopped, or still waiting for the first trigger edge
  assign active_o = en_i & ~stopped_q &
                    (~cfg_i.start_on_trig | started_q | trig_evt);

  assign hold = (cfg_i.pause_on_trig & trig_i) |
                (dbg_halt_i & ~cfg_i.dbg_run);

  assign advance_o = active_o & ~hold;
  assign reload_o  = en_i & cfg_i.reload_on_trig & trig_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q    <= 1'b0;
      started_q <= 1'b0;
      stopped_q <= 1'b0;
    end else begin
      trig_q    <= trig_i;
      started_q <= en_i & (started_q | trig_evt);
      stopped_q <= en_i & (stopped_q | (wrap_i & cfg_i.stop_on_ovf));
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            adv_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (i < int'(ps_i));
  end

  assign tick_o = adv_i & ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else if (adv_i)   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             wrap_o,
  output logic             ovf_pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  dir_e             dir_q;
  logic             ovf_q;
  logic             at_top, going_down;

  assign going_down = center_i & (dir_q == DIR_DOWN) & (cnt_q != '0);
  assign at_top     = ~going_down & (cnt_q >= mod_i);
  assign wrap_o     = tick_i & ~reload_i & at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= wrap_o;
      if (reload_i) begin
        cnt_q <= '0;
        dir_q <= DIR_UP;
      end else if (tick_i) begin
        if (!center_i) begin
          dir_q <= DIR_UP;
          cnt_q <= at_top ? '0 : cnt_q + 1'b1;
        end else if (going_down) begin
          cnt_q <= cnt_q - 1'b1;
          dir_q <= (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}) ? DIR_UP : DIR_DOWN;
        end else if (at_top) begin
          if (cnt_q == '0) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
          end else begin
            cnt_q <= cnt_q - 1'b1;
            dir_q <= (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}) ? DIR_UP : DIR_DOWN;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
          dir_q <= DIR_UP;
        end
      end
    end
  end

  assign count_o     = cnt_q;
  assign dir_down_o  = (dir_q == DIR_DOWN);
  assign ovf_pulse_o = ovf_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic [CNT_W-1:0] mod_i,
  input  logic             center_i,
  input  logic             trig_i,
  input  logic             start_on_trig_i,
  input  logic             stop_on_ovf_i,
  input  logic             reload_on_trig_i,
  input  logic             pause_on_trig_i,
  input  logic             dbg_run_i,
  input  logic             dbg_halt_i,
  input  logic             ovf_ie_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             ovf_pulse_o,
  output logic             ovf_flag_o,
  output logic             irq_o
);
  run_cfg_t cfg;
  logic     active, advance, reload, tick, wrap, flag_q;

  assign cfg = '{start_on_trig:  start_on_trig_i,
                 stop_on_ovf:    stop_on_ovf_i,
                 reload_on_trig: reload_on_trig_i,
                 pause_on_trig:  pause_on_trig_i,
                 dbg_run:        dbg_run_i};

  tmr_trig_ctl u_ctl (
    .clk_i, .rst_ni, .en_i, .trig_i, .dbg_halt_i,
    .cfg_i     (cfg),
    .wrap_i    (wrap),
    .active_o  (active),
    .advance_o (advance),
    .reload_o  (reload)
  );

  tmr_prescaler #(.PS_W(PS_W)) u_pre (
    .clk_i, .rst_ni,
    .clear_i (~active | reload),
    .adv_i   (advance & ~reload),
    .ps_i,
    .tick_o  (tick)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .tick_i      (tick),
    .reload_i    (reload),
    .center_i,
    .mod_i,
    .count_o,
    .dir_down_o,
    .wrap_o      (wrap),
    .ovf_pulse_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (wrap)      flag_q <= 1'b1;
    else if (ovf_clr_i) flag_q <= 1'b0;
  end

  assign ovf_flag_o = flag_q;
  assign irq_o      = flag_q & ovf_ie_i;
endmodule

// File: rtl/tick_timer_sva.sv
module tick_timer_sva #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [PS_W-1:0]  ps_i,
  input logic [CNT_W-1:0] mod_i,
  input logic             center_i,
  input logic             trig_i,
  input logic             reload_on_trig_i,
  input logic             pause_on_trig_i,
  input logic             dbg_run_i,
  input logic             dbg_halt_i,
  input logic             ovf_ie_i,
  input logic             ovf_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_pulse_o,
  input logic             ovf_flag_o,
  input logic             irq_o
);
  a_r2_edge_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!center_i && $stable(mod_i) && $past(count_o) <= $past(mod_i)) |-> count_o <= mod_i);

  a_r4_pulse_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_pulse_o && !center_i && $past(!center_i)) |-> count_o == '0);

  a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_pulse_o && mod_i != '0) |=> !ovf_pulse_o);

  a_r5_flag_follows_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_pulse_o |-> ovf_flag_o);

  a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);

  a_r5_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_ie_i |-> !irq_o);

  a_r6_disabled_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(count_o));

  a_r10_pause_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_on_trig_i && trig_i && !reload_on_trig_i) |=> $stable(count_o));

  a_r11_debug_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_halt_i && !dbg_run_i && !reload_on_trig_i) |=> $stable(count_o));
endmodule

bind tick_timer tick_timer_sva #(.CNT_W(CNT_W), .PS_W(PS_W)) u_sva (.*);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 0, center_i = 0, trig_i = 0;
  logic [2:0]  ps_i = '0;
  logic [15:0] mod_i = '0;
  logic        start_on_trig_i = 0, stop_on_ovf_i = 0, reload_on_trig_i = 0;
  logic        pause_on_trig_i = 0, dbg_run_i = 0, dbg_halt_i = 0;
  logic        ovf_ie_i = 0, ovf_clr_i = 0;
  logic [15:0] count_o;
  logic        dir_down_o, ovf_pulse_o, ovf_flag_o, irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  tick_timer u0 (.*);

  // ps, mod, center, clocks
  localparam int VEC [10][4] = '{
    '{0, 5, 0, 3}, '{0, 5, 0, 8}, '{1, 4, 0, 9}, '{2, 3, 0, 20}, '{0, 0, 0, 5},
    '{0, 4, 1, 6}, '{1, 3, 1, 9}, '{0, 6, 1, 4}, '{0, 1, 1, 3}, '{3, 2, 1, 40}};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; en_i = 0; trig_i = 0; center_i = 0; ps_i = '0;
    start_on_trig_i = 0; stop_on_ovf_i = 0; reload_on_trig_i = 0;
    pause_on_trig_i = 0; dbg_run_i = 0; dbg_halt_i = 0; ovf_ie_i = 0; ovf_clr_i = 0;
    step(1);
    rst_ni = 1;
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    int ticks, p, exp_cnt, exp_dir, exp_flag, c0;
    do_reset();
    step(1);
    check("R6 reset count", count_o, 0);
    check("R5 reset flag", ovf_flag_o, 0);
    check("R3 reset dir", dir_down_o, 0);

    // R1 R2 R3 table sweep
    for (int v = 0; v < 10; v++) begin
      do_reset();
      ps_i = VEC[v][0]; mod_i = VEC[v][1]; center_i = VEC[v][2][0];
      en_i = 1;
      step(VEC[v][3]);
      ticks = VEC[v][3] >> VEC[v][0];
      if (VEC[v][2] == 0) begin
        exp_cnt = ticks % (VEC[v][1] + 1);
        exp_dir = 0;
      end else begin
        p = ticks % (2 * VEC[v][1]);
        exp_cnt = (p <= VEC[v][1]) ? p : 2 * VEC[v][1] - p;
        exp_dir = (p > VEC[v][1]) ? 1 : 0;
      end
      exp_flag = (ticks >= VEC[v][1] + 1) ? 1 : 0;
      check(VEC[v][2] ? "R3 count" : "R1 R2 count", count_o, exp_cnt);
      check("R3 direction", dir_down_o, exp_dir);
      check("R5 flag after run", ovf_flag_o, exp_flag);
    end

    // R4 pulse position, R5 clear and irq
    do_reset();
    mod_i = 3; en_i = 1;
    step(4);
    check("R4 pulse at wrap", ovf_pulse_o, 1);
    check("R4 count at pulse", count_o, 0);
    step(1);
    check("R4 pulse one cycle", ovf_pulse_o, 0);
    check("R5 irq disabled", irq_o, 0);
    ovf_ie_i = 1;
    step(1);
    check("R5 irq enabled", irq_o, 1);
    ovf_clr_i = 1;
    step(1);
    ovf_clr_i = 0;
    check("R5 flag cleared", ovf_flag_o, 0);
    check("R5 irq after clear", irq_o, 0);

    // R4 centre-aligned pulse at MOD-1
    do_reset();
    mod_i = 3; center_i = 1; en_i = 1;
    step(4);
    check("R4 centre pulse", ovf_pulse_o, 1);
    check("R4 centre count at pulse", count_o, 2);

    // R6 disable holds
    do_reset();
    mod_i = 20; en_i = 1;
    step(5);
    en_i = 0;
    step(4);
    check("R6 hold while disabled", count_o, 5);

    // R7 start on trigger, held trigger
    do_reset();
    mod_i = 50; start_on_trig_i = 1; en_i = 1;
    step(5);
    check("R7 waits for trigger", count_o, 0);
    trig_i = 1;
    step(3);
    check("R7 started on edge", count_o, 3);
    trig_i = 0;
    step(2);
    check("R7 keeps running", count_o, 5);

    // R8 stop on overflow and restart
    do_reset();
    mod_i = 2; stop_on_ovf_i = 1; en_i = 1;
    step(3);
    check("R8 wrapped", count_o, 0);
    step(5);
    check("R8 frozen", count_o, 0);
    en_i = 0;
    step(1);
    en_i = 1;
    step(2);
    check("R8 restart after enable", count_o, 2);

    // R9 reload on trigger edge
    do_reset();
    mod_i = 9; reload_on_trig_i = 1; en_i = 1;
    step(5);
    check("R9 before reload", count_o, 5);
    trig_i = 1;
    step(1);
    check("R9 reloaded", count_o, 0);
    check("R9 no overflow", ovf_flag_o, 0);
    step(2);
    check("R9 held trigger reloads once", count_o, 2);
    trig_i = 0;

    // R10 pause while trigger high
    do_reset();
    mod_i = 30; pause_on_trig_i = 1; en_i = 1;
    step(3);
    trig_i = 1;
    step(4);
    check("R10 paused", count_o, 3);
    trig_i = 0;
    step(2);
    check("R10 resumed", count_o, 5);

    // R11 debug halt
    do_reset();
    mod_i = 30; en_i = 1;
    step(2);
    dbg_halt_i = 1;
    step(4);
    check("R11 halted", count_o, 2);
    dbg_run_i = 1;
    step(3);
    c0 = count_o;
    check("R11 runs with debug-run", c0, 5);
    dbg_halt_i = 0; dbg_run_i = 0;

    done = 1;
    report();
    $finish;
  end
endmodule